// File: doc/BRIEF.md
# DMA Event Selector Crossbar

This block sits in front of a sixteen-channel DMA controller and decides which hardware event pulse drives each channel's request line. Software writes a 6-bit selector code for each remappable channel into a small set of 32-bit registers. When the event that a code names pulses, every channel holding that code raises its request one clock later. Channels 8 to 11 cannot be remapped. Their requests come straight from four transfer-complete chaining pulses, so those four channels carry no selector field.

The register port is synchronous. A write lands on a clock edge. Read data is registered, so it shows the contents one cycle after the address is presented. A selector code above 15 selects nothing. Codes 8, 9 and 11 name no source and also stay silent. Code 10 names an event that no channel holds at reset, but any channel may pick it.

Top module: `evsel_xbar`

## Requirements
- R1: After reset, every selectable channel's field holds its own channel number. The register at byte offset 0x0 reads 0x03020100, offset 0x4 reads 0x07060504, offset 0xC reads 0x0F0E0D0C, and all requests are low.
- R2: A selectable channel whose code c is 0 to 7, 10 or 12 to 15 asserts its request exactly one cycle after event input bit c pulses, for one cycle. It stays low for a pulse on any other event bit.
- R3: A selectable channel holding code 8, 9 or 11 never asserts, whatever the event inputs do.
- R4: A selectable channel holding any code from 16 to 63 never asserts.
- R5: Request outputs 8, 9, 10 and 11 follow chaining inputs 0, 1, 2 and 3, one cycle later. They ignore the event inputs and the selector contents.
- R6: When several channels hold the same live code, a pulse on that event asserts all of their requests in the same cycle.
- R7: The selector fields sit at bits [5:0], [13:8], [21:16] and [29:24] of each register, with the lowest channel in the lowest field. Offset 0x0 holds channels 0 to 3, offset 0x4 holds channels 4 to 7, and offset 0xC holds channels 12 to 15. Address bits [1:0] are ignored, and a written value reads back one cycle after its address is presented.
- R8: Bits 7:6, 15:14, 23:22 and 31:30 always read zero, and writing them has no effect. Offset 0x8 reads zero, and a write to it changes no field.
- R9: A selector write takes effect from the next cycle. An event pulse in the same cycle as the write is routed with the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for last cycle's address |
| evt_i | input | 16 | Event pulses, bit index equals selector code |
| chain_i | input | 4 | Chaining pulses for channels 8 to 11 |
| req_o | output | 16 | Registered channel request pulses |

## Verification
A selector update and an event pulse can arrive in the same cycle, and the outcome depends on which mapping the pulse is routed with. The bench writes channel 0 a new code while it pulses that channel's old event on the same edge. It expects the request from the old mapping one cycle later. Pulses on the old and new events after that show that only the new code is live. A chaining pulse can also coincide with a burst on every event line. The bench judges that case by checking that outputs 8 to 11 match the chaining pattern exactly, while the selectable channels react only to their own codes.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
    localparam int NUM_CH     = 16;
    localparam int NUM_EVT    = 16;
    localparam int NUM_CHAIN  = 4;
    localparam int CHAIN_BASE = 8;
    localparam int CODE_W     = 6;
    localparam int LANE_W     = 8;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 4;
    localparam int GAP_WORD   = 2;
    localparam logic [NUM_EVT-1:0] DEAD_CODES = 16'h0B00;

    localparam int EVT_IDX_W  = $clog2(NUM_EVT);
    localparam int NUM_SEL    = NUM_CH - NUM_CHAIN;
    localparam int LANES      = REG_W / LANE_W;
    localparam int NUM_REG    = NUM_SEL / LANES;
    localparam int WORD_W     = ADDR_W - 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [NUM_CH-1:0]     req;
        logic [REG_W-1:0]      rdata;
        code_t [NUM_SEL-1:0]   sel;
    } xbar_state_t;

    function automatic int sel_to_ch(input int s);
        return (s < CHAIN_BASE) ? s : s + NUM_CHAIN;
    endfunction

    function automatic int reg_word(input int r);
        return (r < GAP_WORD) ? r : r + 1;
    endfunction
endpackage

// File: rtl/evsel_wr_decode.sv
module evsel_wr_decode
    import evsel_pkg::*;
(
    input  code_t [NUM_SEL-1:0] sel_q,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    output code_t [NUM_SEL-1:0] sel_d,
    output logic [REG_W-1:0]    rdata_d
);
    logic [WORD_W-1:0]             word;
    logic [NUM_REG-1:0]            hit;
    logic [NUM_REG-1:0][REG_W-1:0] img;

    assign word = addr[ADDR_W-1:2];

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        assign hit[r] = (word == WORD_W'(reg_word(r)));
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int S = r * LANES + l;
            assign sel_d[S] = (we && hit[r]) ? wdata[l*LANE_W +: CODE_W] : sel_q[S];
            assign img[r][l*LANE_W +: LANE_W] = {{(LANE_W-CODE_W){1'b0}}, sel_q[S]};
        end
    end

    always_comb begin
        rdata_d = '0;
        for (int r = 0; r < NUM_REG; r++) begin
            if (hit[r]) rdata_d = img[r];
        end
    end
endmodule

// File: rtl/evsel_route.sv
module evsel_route
    import evsel_pkg::*;
(
    input  code_t [NUM_SEL-1:0] sel_q,
    input  logic [NUM_EVT-1:0]  evt,
    input  logic [NUM_CHAIN-1:0] chain,
    output logic [NUM_CH-1:0]   req_d
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        if (ch >= CHAIN_BASE && ch < CHAIN_BASE + NUM_CHAIN) begin : g_chain
            assign req_d[ch] = chain[ch-CHAIN_BASE];
        end else begin : g_sel
            localparam int S = (ch < CHAIN_BASE) ? ch : ch - NUM_CHAIN;
            logic [EVT_IDX_W-1:0] idx;
            logic                 in_range;
            assign idx      = sel_q[S][EVT_IDX_W-1:0];
            assign in_range = (sel_q[S][CODE_W-1:EVT_IDX_W] == '0);
            assign req_d[ch] = in_range && !DEAD_CODES[idx] && evt[idx];
        end
    end
endmodule

// File: rtl/evsel_xbar.sv
module evsel_xbar
    import evsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NUM_EVT-1:0]   evt_i,
    input  logic [NUM_CHAIN-1:0] chain_i,
    output logic [NUM_CH-1:0]    req_o
);
    function automatic xbar_state_t reset_state();
        xbar_state_t s;
        s.req   = '0;
        s.rdata = '0;
        for (int i = 0; i < NUM_SEL; i++) s.sel[i] = CODE_W'(sel_to_ch(i));
        return s;
    endfunction

    xbar_state_t          st_d, st_q;
    code_t [NUM_SEL-1:0]  sel_q;
    code_t [NUM_SEL-1:0]  sel_nx;
    logic [REG_W-1:0]     rdata_nx;
    logic [NUM_CH-1:0]    req_nx;

    assign sel_q = st_q.sel;

    evsel_wr_decode u_wr (
        .sel_q   (sel_q),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .sel_d   (sel_nx),
        .rdata_d (rdata_nx)
    );

    evsel_route u_route (
        .sel_q (sel_q),
        .evt   (evt_i),
        .chain (chain_i),
        .req_d (req_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sel   = sel_nx;
        st_d.rdata = rdata_nx;
        st_d.req   = req_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign req_o     = st_q.req;
endmodule

// File: rtl/evsel_xbar_chk.sv
module evsel_xbar_chk
    import evsel_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic [NUM_EVT-1:0]   evt_i,
    input logic [NUM_CHAIN-1:0] chain_i,
    input logic [NUM_CH-1:0]    req_o,
    input code_t [NUM_SEL-1:0]  sel_q
);
    a_r5_chain_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> req_o[CHAIN_BASE +: NUM_CHAIN] == $past(chain_i));

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0 && chain_i == '0) |=> req_o == '0);

    a_r2_route_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[0][CODE_W-1:EVT_IDX_W] == '0 && !DEAD_CODES[sel_q[0][EVT_IDX_W-1:0]])
        |=> req_o[0] == $past(evt_i[sel_q[0][EVT_IDX_W-1:0]]));

    a_r3_dead_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[0] == 6'd8 || sel_q[0] == 6'd9 || sel_q[0] == 6'd11) |=> !req_o[0]);

    a_r4_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[0][CODE_W-1:EVT_IDX_W] != '0) |=> !req_o[0]);

    a_r6_fanout_match: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[0] == sel_q[1]) |=> req_o[0] == req_o[1]);

    a_r8_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[ADDR_W-1:2] == 2'd2) |=> reg_rdata == '0);

    a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (reg_rdata & 32'hC0C0_C0C0) == '0);

    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[ADDR_W-1:2] == 2'd0) |=> sel_q[0] == $past(reg_wdata[CODE_W-1:0]));
endmodule

bind evsel_xbar evsel_xbar_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_i     (evt_i),
    .chain_i   (chain_i),
    .req_o     (req_o),
    .sel_q     (sel_q)
);

// File: tb/evsel_xbar_bench.sv
module evsel_xbar_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] evt_i = '0;
    logic [3:0]  chain_i = '0;
    logic [15:0] req_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evsel_xbar u_evsel_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_i     (evt_i),
        .chain_i   (chain_i),
        .req_o     (req_o)
    );

    function automatic int ch_of(input int s);
        return (s < 8) ? s : s + 4;
    endfunction

    function automatic logic [3:0] addr_of(input int r);
        return (r == 0) ? 4'h0 : (r == 1) ? 4'h4 : 4'hC;
    endfunction

    function automatic bit live(input int code);
        return code < 16 && code != 8 && code != 9 && code != 11;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [15:0] e, input logic [3:0] c, output logic [15:0] got);
        evt_i = e; chain_i = c;
        @(negedge clk);
        evt_i = '0; chain_i = '0;
        got = req_o;
    endtask

    task automatic load_all(input int code);
        for (int r = 0; r < 3; r++) wr(addr_of(r), {4{2'b00, 6'(code)}});
    endtask

    task automatic load_identity();
        wr(4'h0, 32'h03020100);
        wr(4'h4, 32'h07060504);
        wr(4'hC, 32'h0F0E0D0C);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic [15:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(req_o == '0, "R1 requests low", 32'(req_o), 32'd0);
        rd_check(4'h0, 32'h03020100, "R1 reg0 default");
        rd_check(4'h4, 32'h07060504, "R1 reg1 default");
        rd_check(4'hC, 32'h0F0E0D0C, "R1 reg3 default");

        // R7 layout, bits [1:0] ignored
        wr(4'h7, 32'h0A0B0C0D);
        rd_check(4'h4, 32'h0A0B0C0D, "R7 readback offset 4");
        rd_check(4'hD, 32'h0F0E0D0C, "R7 offset C untouched");

        // R8 pad bits and gap
        wr(4'h0, 32'hFFFFFFFF);
        rd_check(4'h0, 32'h3F3F3F3F, "R8 pad bits read zero");
        wr(4'h8, 32'h01010101);
        rd_check(4'h8, 32'h0, "R8 gap reads zero");
        rd_check(4'h0, 32'h3F3F3F3F, "R8 gap write no effect reg0");
        rd_check(4'h4, 32'h0A0B0C0D, "R8 gap write no effect reg1");
        rd_check(4'hC, 32'h0F0E0D0C, "R8 gap write no effect reg3");

        // R2 R3 R4 exhaustive sweep: one channel programmed, others reserved
        for (int s = 0; s < 12; s++) begin
            for (int code = 0; code < 64; code++) begin
                for (int r = 0; r < 3; r++) begin
                    logic [31:0] v;
                    for (int l = 0; l < 4; l++)
                        v[l*8 +: 8] = (r*4 + l == s) ? 8'(code) : 8'd63;
                    wr(addr_of(r), v);
                end
                for (int e = 0; e < 16; e++) begin
                    pulse(16'(1) << e, 4'h0, got);
                    exp = '0;
                    if (live(code) && e == code) exp[ch_of(s)] = 1'b1;
                    check(got == exp, code >= 16 ? "R4 reserved code" :
                          (live(code) ? "R2 routing" : "R3 dead code"), 32'(got), 32'(exp));
                end
            end
        end

        // R5 chaining
        load_all(63);
        for (int c = 0; c < 16; c++) begin
            pulse(16'hFFFF, 4'(c), got);
            exp = 16'(c) << 8;
            check(got == exp, "R5 chain only", 32'(got), 32'(exp));
        end
        load_identity();
        for (int c = 0; c < 16; c++) begin
            pulse(16'hFFFF, 4'(c), got);
            exp = 16'hF0FF | (16'(c) << 8);
            check(got == exp, "R5 chain with events", 32'(got), 32'(exp));
        end

        // R6 fan-out: every selectable channel on codes 5 and 10
        load_all(5);
        pulse(16'h0020, 4'h0, got);
        check(got == 16'hF0FF, "R6 fanout code 5", 32'(got), 32'hF0FF);
        load_all(10);
        pulse(16'h0400, 4'h0, got);
        check(got == 16'hF0FF, "R6 fanout code 10", 32'(got), 32'hF0FF);

        // R9 write and event in the same cycle
        load_identity();
        reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h03020103; evt_i = 16'h0001;
        @(negedge clk);
        reg_we = 1'b0; evt_i = '0;
        check(req_o == 16'h0001, "R9 old mapping same cycle", 32'(req_o), 32'h0001);
        pulse(16'h0001, 4'h0, got);
        check(got == 16'h0000, "R9 old code now dead", 32'(got), 32'h0000);
        pulse(16'h0008, 4'h0, got);
        check(got == 16'h0009, "R9 new mapping", 32'(got), 32'h0009);
        @(negedge clk);
        check(req_o == 16'h0000, "R2 one-cycle pulse", 32'(req_o), 32'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule